// File: doc/BRIEF.md
# Masked-Write Soft Reset Register Bank

This block holds the software-controlled reset lines of a group of peripherals. Each stored bit drives one reset line, and a value of 1 holds that peripheral in reset. The registers sit on a simple single-cycle register bus. A transfer has a valid strobe, a write flag, a word address, 32-bit write data and combinational read data. The registers occupy consecutive word addresses, so their byte stride is 4. All reset lines leave the block as one flat vector, and each line comes straight from a flop.

A compile-time flag selects the write behaviour. In masked mode each register holds 16 lines. The upper halfword of a write acts as a per-bit enable for the lower halfword, so software can assert or release one line without a read-modify-write and without a lock. In plain mode each register holds 32 lines, and a write replaces the whole register. Reset index i is stored in register i / N at bit i % N, where N is 16 in masked mode and 32 in plain mode. The bank therefore has register-count times N lines.

Top module: `softrst_bank`

## Requirements
- R1: While rst_n is low, every stored bit is 0, so all reset lines are released. This holds until the first write after reset.
- R2: In masked mode, a write with write-data bit 16+k set loads bit k of the addressed register from write-data bit k, for k from 0 to 15. A 1 asserts the line and a 0 releases it.
- R3: In masked mode, a stored bit whose enable (write-data bit 16+k) is 0 keeps its value across the write.
- R4: In masked mode, a read returns the 16 stored bits in bits 15:0 and zeros in bits 31:16.
- R5: In plain mode, a write replaces all 32 bits of the addressed register, and a read returns all 32 stored bits.
- R6: Word address a selects register a. Output line i is bit i % N of register i / N.
- R7: A write to a word address at or above the register count changes no line. A read from such an address returns 0.
- R8: A cycle with bus_valid low, or a read (bus_write low), leaves every line unchanged. bus_rdata is 0 whenever no read is in progress.
- R9: A write takes effect on rst_lines at the first rising clock edge where bus_valid and bus_write are high, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Transfer strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (4) | Word address of the register |
| bus_wdata | input | 32 | Write data; in masked mode bits 31:16 are per-bit enables |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the read |
| rst_lines | output | NUM_REGS*N (64 masked, 128 plain) | Soft reset lines, 1 = asserted |

## Verification
The stimulus table is applied to a masked-mode instance and a plain-mode instance at the same time, and the two respond differently to the same words.

- A word with all enables clear and all data bits set tells masked mode apart from plain mode: the masked instance must not change, while the plain instance takes every bit.
- Words whose enables cover only part of the data separate the bits that are set, the bits that are cleared and the bits that are held.
- A write to an address past the last register shows whether the address decode wraps onto a real register.
- Read-backs of every register show whether the line-to-register mapping or the upper-half zeroing is wrong.
- A sample taken just before the capturing edge shows whether the outputs update one edge early.

// File: rtl/softrst_pkg.sv
package softrst_pkg;

  // Reset lines held by one register for the selected write mode.
  function automatic int lines_per_reg(input bit masked);
    return masked ? 16 : 32;
  endfunction

  // Masked update: the upper half of wd enables the lower-half bits of cur.
  function automatic logic [15:0] masked_merge(input logic [15:0] cur,
                                               input logic [31:0] wd);
    return (cur & ~wd[31:16]) | (wd[15:0] & wd[31:16]);
  endfunction

endpackage

// File: rtl/softrst_decode.sv
module softrst_decode #(
  parameter int NUM_REGS = 4,
  parameter int ADDR_W   = 4
) (
  input  logic              valid,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_REGS-1:0] wr_sel,
  output logic              rd_hit,
  output logic              in_range
);
  assign in_range = (32'(addr) < 32'(NUM_REGS));
  assign rd_hit   = valid & ~write & in_range;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
    assign wr_sel[g] = valid & write & (addr == ADDR_W'(g));
  end

  // R7: only one register can be written at a time, and none when out of range
  always_comb begin
    a_r7_sel_onehot: assert ($onehot0(wr_sel));
    if (!in_range) a_r7_no_sel_out_of_range: assert (wr_sel == '0);
  end
endmodule

// File: rtl/softrst_reg.sv
module softrst_reg #(
  parameter bit MASKED = 1'b1,
  parameter int W      = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [31:0]   wdata,
  output logic [W-1:0]  q
);
  logic [W-1:0] nxt;

  if (MASKED) begin : g_masked
    assign nxt = W'(softrst_pkg::masked_merge(16'(q), wdata));

    // R2: enabled bits take the written value
    a_r2_enabled_load: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ((q & $past(wdata[16 +: W])) == ($past(wdata[W-1:0]) & $past(wdata[16 +: W]))));
    // R3: bits without enable hold their value
    a_r3_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ((q & ~$past(wdata[16 +: W])) == ($past(q) & ~$past(wdata[16 +: W]))));
  end else begin : g_plain
    assign nxt = W'(wdata);

    // R5: plain write replaces the whole register
    a_r5_full_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (q == $past(wdata[W-1:0])));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= nxt;
  end

  // R8: the register is untouched without its write select
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q));
endmodule

// File: rtl/softrst_readmux.sv
module softrst_readmux #(
  parameter int NUM_REGS = 4,
  parameter int W        = 16,
  parameter int ADDR_W   = 4
) (
  input  logic [NUM_REGS*W-1:0] q_all,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  rd_hit,
  output logic [31:0]           rdata
);
  always_comb begin
    rdata = '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (rd_hit && (32'(addr) == r)) rdata = 32'(q_all[r*W +: W]);
    end
  end
endmodule

// File: rtl/softrst_bank.sv
module softrst_bank #(
  parameter bit MASKED   = 1'b1,
  parameter int NUM_REGS = 4,
  parameter int ADDR_W   = 4,
  localparam int LPR       = softrst_pkg::lines_per_reg(MASKED),
  localparam int NUM_LINES = NUM_REGS * LPR
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic [NUM_LINES-1:0] rst_lines
);
  logic [NUM_REGS-1:0] wr_sel;
  logic                rd_hit;
  logic                in_range;

  softrst_decode #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_decode (
    .valid(bus_valid), .write(bus_write), .addr(bus_addr),
    .wr_sel(wr_sel), .rd_hit(rd_hit), .in_range(in_range)
  );

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    softrst_reg #(.MASKED(MASKED), .W(LPR)) u_reg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_sel[r]), .wdata(bus_wdata),
      .q(rst_lines[r*LPR +: LPR])
    );
  end

  softrst_readmux #(.NUM_REGS(NUM_REGS), .W(LPR), .ADDR_W(ADDR_W)) u_readmux (
    .q_all(rst_lines), .addr(bus_addr), .rd_hit(rd_hit), .rdata(bus_rdata)
  );

  // R1: the first cycle after reset sees all lines released
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (rst_lines == '0));
  // R8/R9: the line vector moves only after an accepted write
  a_r9_change_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && bus_write) |=> $stable(rst_lines));
  // R7: out-of-range writes change nothing
  a_r7_oor_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && !in_range) |=> $stable(rst_lines));

  always_comb begin
    // R4/R5/R6: read data mirrors the addressed slice of the line vector
    if (rd_hit) a_r6_read_mirrors_lines:
      assert (bus_rdata == 32'(rst_lines[32'(bus_addr)*LPR +: LPR]));
    // R8: no read, no data
    if (!(bus_valid && !bus_write)) a_r8_rdata_idle_zero: assert (bus_rdata == '0);
  end
endmodule

// File: tb/softrst_bank_bench.sv
module softrst_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 4;
  localparam int NVEC = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata_m, rdata_p;
  logic [63:0] lines_m;
  logic [127:0] lines_p;

  logic [63:0]  exp_m = '0;
  logic [127:0] exp_p = '0;
  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  softrst_bank #(.MASKED(1'b1), .NUM_REGS(NREG), .ADDR_W(4)) u_softrst_bank (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_m), .rst_lines(lines_m)
  );
  softrst_bank #(.MASKED(1'b0), .NUM_REGS(NREG), .ADDR_W(4)) u_softrst_bank_plain (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_p), .rst_lines(lines_p)
  );

  // stimulus vectors {word address, write data}
  localparam logic [35:0] VEC [NVEC] = '{
    {4'd0, 32'h0001_0001},   // R2 assert line 0
    {4'd1, 32'hFFFF_A5A5},   // R2/R5 full-enable pattern
    {4'd1, 32'h00F0_0000},   // R2 release bits 4..7 only
    {4'd3, 32'h8000_8000},   // R6 top line
    {4'd0, 32'h0000_FFFF},   // R3 no enables
    {4'd2, 32'h0F0F_FFFF},   // R3 partial enables
    {4'd5, 32'hFFFF_FFFF},   // R7 out of range
    {4'd0, 32'h0001_0000}    // R2 release line 0
  };

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bench-side model: per line index, register = i / N, bit = i % N
  task automatic model_write(input logic [3:0] a, input logic [31:0] wd);
    if (a < NREG) begin
      for (int i = 0; i < 64; i++)
        if (i / 16 == a && wd[16 + i % 16]) exp_m[i] = wd[i % 16];
      for (int i = 0; i < 128; i++)
        if (i / 32 == a) exp_p[i] = wd[i % 32];
    end
  endtask

  task automatic do_write(input logic [3:0] a, input logic [31:0] wd);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = wd;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    model_write(a, wd);
  endtask

  task automatic check_lines(input string req);
    chk({req, " masked lines"}, 128'(lines_m), 128'(exp_m));
    chk({req, " plain lines"}, lines_p, exp_p);
  endtask

  task automatic check_read(input logic [3:0] a, input string req);
    logic [31:0] em, ep;
    em = '0; ep = '0;
    if (a < NREG) begin
      for (int k = 0; k < 16; k++) em[k] = exp_m[a*16 + k];
      for (int k = 0; k < 32; k++) ep[k] = exp_p[a*32 + k];
    end
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1;
    chk({req, " masked read"}, 128'(rdata_m), 128'(em));
    chk({req, " plain read"}, 128'(rdata_p), 128'(ep));
    @(negedge clk);
    bus_valid = 1'b0;
    #1;
    chk({req, " R8 idle rdata"}, 128'({rdata_m, rdata_p}), 128'(0));
    check_lines({req, " R8 read no effect"});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_lines("R1 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_lines("R1 after reset");
    check_read(4'd0, "R1");

    for (int v = 0; v < NVEC; v++) begin
      do_write(VEC[v][35:32], VEC[v][31:0]);
      check_lines("R2 R3 R5 R6 R7 table");
      check_read(VEC[v][35:32], "R4 R5 R6 R7 table");
    end
    for (int a = 0; a < 6; a++) check_read(4'(a), "R6 R7 sweep");

    // R8: write flag with valid low
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b1; bus_addr = 4'd2; bus_wdata = 32'hFFFF_0000;
    @(negedge clk);
    bus_write = 1'b0;
    check_lines("R8 valid low");

    // R9: nothing before the edge, update right after it
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 4'd2; bus_wdata = 32'h0001_0001;
    #1;
    check_lines("R9 before edge");
    @(posedge clk);
    model_write(4'd2, 32'h0001_0001);
    #1;
    check_lines("R9 after edge");
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;

    // R4: masked read upper half is zero even after an all-ones write
    do_write(4'd3, 32'hFFFF_FFFF);
    check_read(4'd3, "R4");
    chk("R4 upper half", 128'(lines_m[63:48]), 128'(16'hFFFF));

    // R1: reset in mid-run clears everything
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    exp_m = '0; exp_p = '0;
    check_lines("R1 mid-run reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_lines("R1 after release");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule